// File: doc/BRIEF.md
# Six-Pin Shared Parallel Port

This block is a six-pin general-purpose parallel port for a small controller. Software reaches it through a minimal register bus that has a write strobe, a read strobe and a one-bit register select. Two registers sit behind that bus: an output latch and a direction mask. Each pin can also be taken over by a digital peripheral or by an analog peripheral. A fixed priority decides who controls the pad: analog first, then digital, then the port's own registers.

For every pin the block drives registered pad controls: an output level, an output enable and an input-buffer enable. It also returns a synchronized copy of the pad levels to the peripherals. A read of the latch register takes each bit from one of three sources. If the pin's direction bit is set, the bit comes from the latch. If the direction bit is clear, the bit comes from the synchronized pad. If the direction bit is clear and the pin's input buffer is off, the bit reads as zero. The direction bit picks the source even while a peripheral owns the pin. A low-power hold input freezes the pad controls so that the pins keep their state until the hold is released.

Top module: `gpio_shared_port`

## Requirements
- R1: After reset, the latch and direction registers read as 0, and pad_oe, pad_ie and reg_rdata are 0.
- R2: On a pin with no peripheral enabled, pad_out follows the latch bit, pad_oe follows the direction bit (1 = output) and pad_ie is 1. All pad controls are registered and update one clock after their cause.
- R3: A write to the latch stores its value whatever the direction bits are. A value written while a pin is an input is driven as soon as the pin's pad_oe first goes high.
- R4: When alt_en is set and ana_en is clear on a pin, pad_out and pad_oe come from alt_out and alt_oe, and pad_ie is 1. The latch and direction bits no longer drive that pad.
- R5: A latch read returns, for each pin, the latch bit if the direction bit is 1 and the synchronized pad level if it is 0. This holds even while a digital peripheral owns the pin.
- R6: When ana_en is set on a pin, pad_oe, pad_ie and pad_out of that pin are 0.
- R7: A latch read of a pin whose direction bit is 0 and whose input buffer is off (analog enabled) returns 0.
- R8: When both alt_en and ana_en are set on a pin, the analog rule R6 applies.
- R9: While lp_hold is 1, pad_out, pad_oe and pad_ie keep their values. Register writes still land. One clock after lp_hold falls, the pads reflect the current configuration.
- R10: sync_in equals pad_in as it was two rising edges earlier.
- R11: reg_addr 0 selects the latch and 1 selects the direction register. reg_rdata is loaded on the clock edge that samples reg_rd and holds otherwise. Bits 7:6 always read 0, and written bits 7:6 are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_hold | input | 1 | Low-power hold, freezes the pad controls |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = latch, 1 = direction |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| alt_en | input | 6 | Digital peripheral claims the pin |
| alt_out | input | 6 | Digital peripheral output level |
| alt_oe | input | 6 | Digital peripheral output enable |
| ana_en | input | 6 | Analog peripheral claims the pin |
| pad_in | input | 6 | Asynchronous pad levels |
| sync_in | output | 6 | Synchronized pad levels |
| pad_out | output | 6 | Pad output level |
| pad_oe | output | 6 | Pad output enable |
| pad_ie | output | 6 | Pad input-buffer enable |

## Verification
A wrong direction or latch bit shows at pad_oe or pad_out one clock after the register write. It also shows at the next latch read, because a wrong direction bit makes that read take the wrong source. Priority faults between analog and digital ownership appear on the pad controls one edge after the enables change. A broken input-buffer gate shows up as a nonzero read bit on an analog pin. Synchronizer depth faults move the edge of sync_in by a cycle, and the bench samples sync_in after each edge to catch this.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic {
    SEL_LATCH = 1'b0,
    SEL_DIR   = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic out;
    logic oe;
    logic ie;
  } pad_ctl_t;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
  parameter int PINS  = 6,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic             addr,
  input  logic [REG_W-1:0] wdata,
  output logic [PINS-1:0]  latch_q,
  output logic [PINS-1:0]  dir_q
);
  import gpio_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (wr) begin
      if (reg_sel_e'(addr) == SEL_LATCH) latch_q <= wdata[PINS-1:0];
      else                               dir_q   <= wdata[PINS-1:0];
    end
  end

  logic unused_hi;
  assign unused_hi = ^wdata[REG_W-1:PINS];
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl (
  input  logic latch_bit,
  input  logic dir_bit,
  input  logic dig_en,
  input  logic dig_out,
  input  logic dig_oe,
  input  logic ana_en,
  input  logic sync_bit,
  output gpio_pkg::pad_ctl_t ctl,
  output logic rd_bit
);
  logic own_path;
  logic dig_path;

  assign own_path = ~dig_en;
  assign dig_path = dig_en;

  always_comb begin
    ctl.oe  = ((own_path & dir_bit) | (dig_path & dig_oe)) & ~ana_en;
    ctl.out = (own_path ? latch_bit : dig_out) & ~ana_en;
    ctl.ie  = ~ana_en;
  end

  always_comb begin
    if (dir_bit)     rd_bit = latch_bit;
    else if (ctl.ie) rd_bit = sync_bit;
    else             rd_bit = 1'b0;
  end
endmodule

// File: rtl/gpio_shared_port.sv
module gpio_shared_port #(
  parameter int PINS        = 6,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lp_hold,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic             reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [PINS-1:0]  alt_en,
  input  logic [PINS-1:0]  alt_out,
  input  logic [PINS-1:0]  alt_oe,
  input  logic [PINS-1:0]  ana_en,
  input  logic [PINS-1:0]  pad_in,
  output logic [PINS-1:0]  sync_in,
  output logic [PINS-1:0]  pad_out,
  output logic [PINS-1:0]  pad_oe,
  output logic [PINS-1:0]  pad_ie
);
  import gpio_pkg::*;

  localparam int PAD_W = REG_W - PINS;

  logic [PINS-1:0] latch_q;
  logic [PINS-1:0] dir_q;
  logic [PINS-1:0] rd_bits;
  logic [PINS-1:0] nxt_out;
  logic [PINS-1:0] nxt_oe;
  logic [PINS-1:0] nxt_ie;

  gpio_regs #(.PINS(PINS), .REG_W(REG_W)) regs_i (
    .clk     (clk),
    .rst     (rst),
    .wr      (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .latch_q (latch_q),
    .dir_q   (dir_q)
  );

  gpio_sync #(.W(PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (sync_in)
  );

  for (genvar p = 0; p < PINS; p++) begin : g_pin
    pad_ctl_t ctl;
    gpio_pin_ctl pin_i (
      .latch_bit (latch_q[p]),
      .dir_bit   (dir_q[p]),
      .dig_en    (alt_en[p]),
      .dig_out   (alt_out[p]),
      .dig_oe    (alt_oe[p]),
      .ana_en    (ana_en[p]),
      .sync_bit  (sync_in[p]),
      .ctl       (ctl),
      .rd_bit    (rd_bits[p])
    );
    assign nxt_out[p] = ctl.out;
    assign nxt_oe[p]  = ctl.oe;
    assign nxt_ie[p]  = ctl.ie;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      pad_ie  <= '0;
    end else if (!lp_hold) begin
      pad_out <= nxt_out;
      pad_oe  <= nxt_oe;
      pad_ie  <= nxt_ie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      if (reg_sel_e'(reg_addr) == SEL_LATCH) reg_rdata <= {{PAD_W{1'b0}}, rd_bits};
      else                                   reg_rdata <= {{PAD_W{1'b0}}, dir_q};
    end
  end
endmodule

// File: rtl/gpio_shared_port_chk.sv
module gpio_shared_port_chk #(
  parameter int PINS  = 6,
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             lp_hold,
  input logic             reg_rd,
  input logic [REG_W-1:0] reg_rdata,
  input logic [PINS-1:0]  alt_en,
  input logic [PINS-1:0]  alt_oe,
  input logic [PINS-1:0]  ana_en,
  input logic [PINS-1:0]  pad_in,
  input logic [PINS-1:0]  sync_in,
  input logic [PINS-1:0]  pad_out,
  input logic [PINS-1:0]  pad_oe,
  input logic [PINS-1:0]  pad_ie
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pad_oe == '0 && pad_ie == '0 && reg_rdata == '0));

  // R6
  analog_off_chk: assert property (@(posedge clk) disable iff (rst)
    !lp_hold |=> (($past(ana_en) & (pad_oe | pad_ie | pad_out)) == '0));

  // R4
  digital_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !lp_hold |=> ((($past(alt_en) & ~$past(ana_en)) & (pad_oe ^ $past(alt_oe))) == '0));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    lp_hold |=> ($stable(pad_out) && $stable(pad_oe) && $stable(pad_ie)));

  // R11
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> (reg_rdata[REG_W-1:PINS] == '0));

  // R10
  sync_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> (sync_in == $past(pad_in, 2)));
endmodule

bind gpio_shared_port gpio_shared_port_chk #(.PINS(PINS), .REG_W(REG_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .lp_hold   (lp_hold),
  .reg_rd    (reg_rd),
  .reg_rdata (reg_rdata),
  .alt_en    (alt_en),
  .alt_oe    (alt_oe),
  .ana_en    (ana_en),
  .pad_in    (pad_in),
  .sync_in   (sync_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .pad_ie    (pad_ie)
);

// File: tb/gpio_shared_port_tb.sv
`timescale 1ns/1ps
module gpio_shared_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       lp_hold = 1'b0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic       reg_addr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [5:0] alt_en = '0, alt_out = '0, alt_oe = '0, ana_en = '0, pad_in = '0;
  logic [5:0] sync_in, pad_out, pad_oe, pad_ie;
  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_shared_port dut_i (
    .clk(clk), .rst(rst), .lp_hold(lp_hold), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alt_en(alt_en), .alt_out(alt_out), .alt_oe(alt_oe), .ana_en(ana_en),
    .pad_in(pad_in), .sync_in(sync_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_ie(pad_ie)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(logic a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    rst = 1'b1; alt_en = '0; alt_out = '0; alt_oe = '0; ana_en = '0;
    pad_in = '0; lp_hold = 1'b0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    do_reset();
    check("R1 pad_oe", {2'b0, pad_oe}, 8'h00);
    check("R1 pad_ie", {2'b0, pad_ie}, 8'h00);
    check("R1 rdata", reg_rdata, 8'h00);
    rd_reg(1'b0, d); check("R1 latch", d, 8'h00);
    rd_reg(1'b1, d); check("R1 dir", d, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] d;
    do_reset();
    wr_reg(1'b0, 8'h15); wr_reg(1'b1, 8'h3F); tick();
    check("R2 out", {2'b0, pad_out}, 8'h15);
    check("R2 oe", {2'b0, pad_oe}, 8'h3F);
    check("R2 ie", {2'b0, pad_ie}, 8'h3F);
    wr_reg(1'b1, 8'h00); tick();
    check("R2 oe input", {2'b0, pad_oe}, 8'h00);
    rd_reg(1'b1, d); check("R11 dir read", d, 8'h00);
  endtask

  task automatic t_prewrite();
    do_reset();
    wr_reg(1'b0, 8'h2A); tick();
    check("R3 oe still off", {2'b0, pad_oe}, 8'h00);
    wr_reg(1'b1, 8'h2A);
    check("R3 registered pad", {2'b0, pad_oe}, 8'h00);
    tick();
    check("R3 first output cycle", {2'b0, pad_out & pad_oe}, 8'h2A);
  endtask

  task automatic t_digital();
    logic [7:0] d;
    do_reset();
    wr_reg(1'b1, 8'h0F);
    alt_en = 6'h03; alt_out = 6'h01; alt_oe = 6'h03; pad_in = 6'h3C;
    tick(); tick();
    check("R4 oe", {2'b0, pad_oe}, 8'h0F);
    check("R4 out", {2'b0, pad_out}, 8'h01);
    check("R4 ie", {2'b0, pad_ie}, 8'h3F);
    rd_reg(1'b0, d); check("R5 mixed sources", d, 8'h30);
    alt_oe = 6'h01; tick();
    check("R4 peripheral oe wins over dir", {2'b0, pad_oe}, 8'h0D);
  endtask

  task automatic t_analog();
    logic [7:0] d;
    do_reset();
    ana_en = 6'h30; pad_in = 6'h3F; tick(); tick();
    check("R6 oe", {2'b0, pad_oe}, 8'h00);
    check("R6 ie", {2'b0, pad_ie}, 8'h0F);
    rd_reg(1'b0, d); check("R7 disabled input reads 0", d, 8'h0F);
    wr_reg(1'b0, 8'h30); wr_reg(1'b1, 8'h30); tick();
    check("R6 oe with dir set", {2'b0, pad_oe}, 8'h00);
    check("R6 out zero", {2'b0, pad_out}, 8'h00);
    rd_reg(1'b0, d); check("R5 latch under analog", d, 8'h3F);
  endtask

  task automatic t_priority();
    do_reset();
    alt_en = 6'h3F; alt_out = 6'h3F; alt_oe = 6'h3F; ana_en = 6'h01; tick();
    check("R8 oe", {2'b0, pad_oe}, 8'h3E);
    check("R8 out", {2'b0, pad_out}, 8'h3E);
    check("R8 ie", {2'b0, pad_ie}, 8'h3E);
  endtask

  task automatic t_hold();
    logic [7:0] d;
    do_reset();
    wr_reg(1'b0, 8'h05); wr_reg(1'b1, 8'h07); tick();
    lp_hold = 1'b1;
    ana_en = 6'h01; alt_en = 6'h02; alt_oe = 6'h00;
    wr_reg(1'b1, 8'h38); tick(); tick();
    check("R9 out held", {2'b0, pad_out}, 8'h05);
    check("R9 oe held", {2'b0, pad_oe}, 8'h07);
    check("R9 ie held", {2'b0, pad_ie}, 8'h3F);
    rd_reg(1'b1, d); check("R9 write landed", d, 8'h38);
    lp_hold = 1'b0; tick();
    check("R9 oe after release", {2'b0, pad_oe}, 8'h38);
    check("R9 ie after release", {2'b0, pad_ie}, 8'h3E);
  endtask

  task automatic t_sync();
    logic [7:0] d;
    do_reset();
    tick(); tick();
    pad_in = 6'h2D;
    tick(); check("R10 one edge", {2'b0, sync_in}, 8'h00);
    tick(); check("R10 two edges", {2'b0, sync_in}, 8'h2D);
    rd_reg(1'b0, d); check("R10 read pin", d, 8'h2D);
  endtask

  task automatic t_regif();
    logic [7:0] d;
    do_reset();
    wr_reg(1'b1, 8'hFF); wr_reg(1'b0, 8'hC9);
    rd_reg(1'b0, d); check("R11 upper bits zero", d, 8'h09);
    rd_reg(1'b1, d); check("R11 dir read", d, 8'h3F);
    tick(); check("R11 rdata holds", reg_rdata, 8'h3F);
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_basic();
    t_prewrite();
    t_digital();
    t_analog();
    t_priority();
    t_hold();
    t_sync();
    t_regif();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule